// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

This block derives a serial-interface clock from a faster reference clock for a shift engine. The division is done in two cascaded stages: a linear counter that divides by `div_lin + 1` (1 to 16) and a binary counter, advanced by the linear stage, that divides by `2**div_exp` (1 to 32768). One full serial-clock period therefore spans `N = (div_lin + 1) * 2**div_exp` reference cycles. When both fields are zero, N is 1 and the serial clock runs at the reference rate.

Besides the `sclk` level, the block gives two single-cycle strobes. `lead_tick` is high in the reference cycle just before sclk leaves its idle level. `trail_tick` is high in the cycle just before sclk returns to idle. A shift engine can use these strobes directly as its shift and sample enables. The divider fields and the polarity bit are captured only on clock edges where `run` is low. While the block runs it ignores them, so a new setting is applied by dropping `run` for at least one cycle.

Cycles are numbered k = 0, 1, 2 … from the first cycle in which `run` is high. Cycle k sits at position `k mod N` inside its period. For N ≥ 2, `lead_tick` fires at position L = floor(N/2) − 1 and `trail_tick` fires at position N − 1.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While running with N ≥ 2, `trail_tick` is high exactly in the cycles k with k mod N = N − 1, where N = (div_lin+1)·2^div_exp. This gives one trailing strobe per N reference cycles.
- R2: While running with N ≥ 2, `lead_tick` is high exactly in the cycles k with k mod N = floor(N/2) − 1. It is never high in the same cycle as `trail_tick`.
- R3: The active phase of sclk begins one cycle after a `lead_tick` cycle and ends one cycle after a `trail_tick` cycle. It holds for period positions floor(N/2) through N − 1, and at all other positions sclk is idle.
- R4: `sclk` equals the active phase XOR the captured polarity. With polarity 1 sclk idles high and is low when active; with polarity 0 it idles low.
- R5: With div_lin = 0 and div_exp = 0 (N = 1), both strobes are high in every running cycle and sclk stays at its idle level.
- R6: While `run` is low, both strobes are low in the same cycle, and from the next clock edge sclk is at the idle level given by the `cpol` input. Raising `run` again restarts the period at position 0.
- R7: `div_lin`, `div_exp` and `cpol` are captured only on edges where `run` is low. Changing them while running has no effect on the strobes or on sclk.
- R8: After synchronous reset with `run` low, sclk is 0 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enable; low holds the dividers cleared and captures settings |
| div_lin | input | 4 | Linear stage setting, divide by value+1 |
| div_exp | input | 4 | Binary stage setting, divide by 2^value |
| cpol | input | 1 | Idle level of sclk |
| sclk | output | 1 | Serial clock level (registered) |
| lead_tick | output | 1 | Strobe in the cycle before sclk goes active |
| trail_tick | output | 1 | Strobe in the cycle before sclk goes idle |

## Verification
The strobes are combinational from the counters and `run`, so they are due in the same cycle as the counter state. The bench samples them one time unit after each falling edge and compares them with the position `k mod N`, which it computes from its own cycle count. The sclk level is registered, so the bench expects it one cycle after the strobe that causes it. After `run` falls, the strobes are checked in that same cycle and the idle sclk level is checked one edge later. For settings changed while running, the bench keeps expecting the old period through the rest of the run.

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
  parameter int PRE_W  = 4,
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PRE_W-1:0]  div_lin,
  input  logic [POST_W-1:0] div_exp,
  input  logic              cpol,
  output logic              sclk,
  output logic              lead_tick,
  output logic              trail_tick
);
  localparam int QW = (1 << POST_W) - 1;

  logic [PRE_W-1:0]  lin_r, p;
  logic [POST_W-1:0] exp_r;
  logic              cpol_r, ph;
  logic [QW-1:0]     q, q_last, q_mid;
  logic [QW:0]       span;
  logic [PRE_W:0]    half;
  logic              bypass, lin_end, lead_c, trail_c;

  assign span    = {{QW{1'b0}}, 1'b1} << exp_r;
  assign q_last  = span[QW-1:0] - 1'b1;
  assign q_mid   = span[QW:1] - 1'b1;
  assign half    = ({1'b0, lin_r} + 1'b1) >> 1;
  assign bypass  = (lin_r == '0) && (exp_r == '0);
  assign lin_end = (p == lin_r);

  assign lead_c  = (exp_r == '0) ? ({1'b0, p} == half - 1'b1)
                                 : (lin_end && q == q_mid);
  assign trail_c = lin_end && (q == q_last);

  assign lead_tick  = run && (bypass || lead_c);
  assign trail_tick = run && (bypass || trail_c);
  assign sclk       = ph ^ cpol_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      lin_r  <= '0;
      exp_r  <= '0;
      cpol_r <= 1'b0;
      p      <= '0;
      q      <= '0;
      ph     <= 1'b0;
    end else if (!run) begin
      lin_r  <= div_lin;
      exp_r  <= div_exp;
      cpol_r <= cpol;
      p      <= '0;
      q      <= '0;
      ph     <= 1'b0;
    end else begin
      p <= lin_end ? '0 : p + 1'b1;
      if (lin_end) q <= (q == q_last) ? '0 : q + 1'b1;
      if (!bypass) begin
        if (lead_c)       ph <= 1'b1;
        else if (trail_c) ph <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk #(
  parameter int PRE_W  = 4,
  parameter int POST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              cpol,
  input logic              sclk,
  input logic              lead_tick,
  input logic              trail_tick,
  input logic              cpol_r,
  input logic [PRE_W-1:0]  lin_r,
  input logic [POST_W-1:0] exp_r
);
  logic bypass;
  assign bypass = (lin_r == '0) && (exp_r == '0);

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!lead_tick && !trail_tick));

  a_r6_idle_after_off: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == $past(cpol)));

  a_r3_active_after_lead: assert property (@(posedge clk) disable iff (rst)
    (run && lead_tick && !trail_tick) |=> (sclk != cpol_r));

  a_r3_idle_after_trail: assert property (@(posedge clk) disable iff (rst)
    (run && trail_tick && !lead_tick) |=> (sclk == cpol_r));

  a_r5_bypass_strobes: assert property (@(posedge clk) disable iff (rst)
    (run && bypass) |-> (lead_tick && trail_tick && sclk == cpol_r));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (run && !bypass) |-> !(lead_tick && trail_tick));
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk #(.PRE_W(PRE_W), .POST_W(POST_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .cpol(cpol), .sclk(sclk),
  .lead_tick(lead_tick), .trail_tick(trail_tick),
  .cpol_r(cpol_r), .lin_r(lin_r), .exp_r(exp_r)
);

// File: tb/test_spi_sclk_prescaler.sv
module test_spi_sclk_prescaler;
  logic clk = 1'b0, rst = 1'b1, run = 1'b0, cpol = 1'b0;
  logic [3:0] div_lin = '0, div_exp = '0;
  logic sclk, lead_tick, trail_tick;
  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_sclk_prescaler i_spi_sclk_prescaler (
    .clk(clk), .rst(rst), .run(run), .div_lin(div_lin), .div_exp(div_exp),
    .cpol(cpol), .sclk(sclk), .lead_tick(lead_tick), .trail_tick(trail_tick)
  );

  task automatic check(string req, logic act, logic exp, int k);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic run_cfg(int lin, int ex, bit cp, int cycles, int chg_at);
    int n, l, pos;
    bit changed;
    @(negedge clk);
    run = 1'b0; div_lin = 4'(lin); div_exp = 4'(ex); cpol = cp;
    @(negedge clk);
    run = 1'b1; #1;
    n = (lin + 1) << ex;
    l = n / 2 - 1;
    changed = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      pos = k % n;
      if (n == 1) begin
        check("R5 lead", lead_tick, 1'b1, k);
        check("R5 trail", trail_tick, 1'b1, k);
        check("R5 sclk", sclk, cp, k);
      end else begin
        check(changed ? "R7 lead" : "R2 lead", lead_tick, pos == l, k);
        check(changed ? "R7 trail" : "R1 trail", trail_tick, pos == n - 1, k);
        check(changed ? "R7 sclk" : (cp ? "R4 sclk" : "R3 sclk"), sclk,
              ((pos >= l + 1) ? 1'b1 : 1'b0) ^ cp, k);
      end
      if (k == chg_at) begin
        div_lin = ~div_lin; div_exp = div_exp + 4'd1; cpol = ~cp;
        changed = 1'b1;
      end
    end
  endtask

  task automatic stop_check();
    @(negedge clk);
    run = 1'b0; #1;
    check("R6 lead off", lead_tick, 1'b0, -1);
    check("R6 trail off", trail_tick, 1'b0, -1);
    @(negedge clk); #1;
    check("R6 sclk idle", sclk, cpol, -1);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; #1;
    check("R8 sclk", sclk, 1'b0, 0);
    check("R8 lead", lead_tick, 1'b0, 0);
    check("R8 trail", trail_tick, 1'b0, 0);

    for (int ex = 0; ex < 4; ex++)
      for (int lin = 0; lin < 16; lin++) begin
        int n;
        n = (lin + 1) << ex;
        run_cfg(lin, ex, 1'(lin % 2), 2 * n + 1, n);
        stop_check();
      end

    run_cfg(15, 8, 1'b0, 4096 + 100, -1);
    stop_check();
    run_cfg(2, 0, 1'b1, 10, -1);
    stop_check();
    run_cfg(1, 12, 1'b1, 2 * 8192, 3000);
    stop_check();
    run_cfg(0, 0, 1'b0, 20, 5);
    stop_check();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule